// File: doc/BRIEF.md
# I/O Space Address Decoder

This block sits between the load/store and in/out paths of a small 8-bit CPU and the peripheral control registers. Peripheral registers are visible through two windows. The in/out instructions use a short 6-bit I/O address. Load/store uses the full 8-bit data address, where the same register appears 0x20 higher. Above the aliased window, an extended register range can be reached only by load/store. The block decodes every request into a storage slot and applies the access rules for its type. It performs single-bit set, clear and test on the lowest 32 I/O registers. It blocks writes to reserved locations.

One register holds status flags that peripherals raise and that software clears by writing a one. The bit-set path changes only the named bit. As a result, setting a flag bit clears that flag alone and leaves every other pending flag alone. The peripherals themselves are represented by a register-file stub inside the block.

Every accepted request is answered one clock later. The answer carries the read data, the tested bit and an illegal-access pulse.

Top module: `iospace_decoder`

## Requirements
- R1: While `rst` is high, `rsp_valid` and `rsp_illegal` are low one cycle later. After reset, every implemented register reads 0x00.
- R2: An I/O access to address a (0x00 to 0x3F) and a data access to address a+0x20 reach the same register. I/O locations 0x00 to 0x02, like any other implemented register, keep any 8-bit value written to them.
- R3: Encoding of `req_op`: 0 = I/O read, 1 = I/O write, 2 = data read, 3 = data write, 4 = bit set, 5 = bit clear, 6 = bit test, 7 = undefined. Each cycle with `req_valid` high gives exactly one cycle of `rsp_valid` at the next clock edge. `rsp_rdata` is 0x00 for every request that is not a read.
- R4: Bit set (op 4) and bit clear (op 5) take an I/O address in 0x00 to 0x1F. They change only bit `req_bit` of an ordinary register.
- R5: Bit test (op 6) returns bit `req_bit` of the addressed register on `rsp_bit`, with `rsp_rdata` = 0x00. `rsp_bit` is 0 for every other request.
- R6: A bit operation with an address of 0x20 or above raises `rsp_illegal` and changes nothing.
- R7: An I/O read or write with an address of 0x40 or above raises `rsp_illegal`, changes nothing, and returns 0x00.
- R8: Data addresses 0x60 to 0x7F (default `EXT_NUM` = 32) are ordinary read/write registers reached through data reads and writes.
- R9: The flag register sits at I/O address 0x16. Bits 3:0 are flags: a one on `hw_flag_set` sets them, and a write of one clears them. Bits 7:4 are ordinary storage. `hw_flag_set` bits 7:4 have no effect.
- R10: A bit set on a flag bit clears only that flag. A bit clear on a flag bit has no effect. Bit operations on bits 7:4 of the flag register act as on an ordinary register.
- R11: The following locations are reserved: data addresses below 0x20, I/O addresses 0x1D and 0x30 to 0x33, and data addresses 0x80 and above. A read of a reserved location returns 0x00. A write to one changes no register. An access to a reserved location is not illegal.
- R12: Op 7 raises `rsp_illegal` and changes nothing.
- R13: A flag raised by `hw_flag_set` in the same cycle as a write of one to that flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Access type (encoding in R3) |
| req_addr | input | 8 | I/O address or data address, depending on the op |
| req_wdata | input | 8 | Write data for full-byte writes |
| req_bit | input | 3 | Bit index for bit operations |
| hw_flag_set | input | 8 | Peripheral event lines that raise flags |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 8 | Read data, 0x00 when the request is not a read |
| rsp_bit | output | 1 | Result of a bit test |
| rsp_illegal | output | 1 | Illegal-access pulse |

## Verification
A wrong offset between the two windows, or a mis-decoded reserved location, shows up at the ports at the first read-back. The read, one cycle after its request, returns the wrong byte or a nonzero reserved value. A bit path that writes the whole byte back shows up at the first read of the flag register after a bit operation: flags that should still be pending have vanished. Lost or duplicated responses, and illegal pulses that are missing or spurious, appear on the response lines in the very cycle after the offending request.

// File: rtl/iospace_pkg.sv
package iospace_pkg;

  typedef enum logic [2:0] {
    OP_IO_RD   = 3'd0,
    OP_IO_WR   = 3'd1,
    OP_MEM_RD  = 3'd2,
    OP_MEM_WR  = 3'd3,
    OP_BIT_SET = 3'd4,
    OP_BIT_CLR = 3'd5,
    OP_BIT_TST = 3'd6,
    OP_NONE    = 3'd7
  } io_op_e;

  localparam logic [7:0] IO_WIN_BASE  = 8'h20;  // data address of I/O location 0
  localparam logic [7:0] EXT_WIN_BASE = 8'h60;  // first extended data address

  typedef struct packed {
    logic       legal;
    logic       reserved;
    logic       is_flag;
    logic [7:0] daddr;
  } io_dec_t;

endpackage

// File: rtl/iospace_map.sv
module iospace_map
  import iospace_pkg::*;
#(
  parameter int unsigned EXT_NUM  = 32,
  parameter logic [63:0] IO_RSVD  = 64'h000F_0000_2000_0000,
  parameter logic [5:0]  FLAG_IO  = 6'h16
) (
  input  io_op_e      op,
  input  logic [7:0]  addr,
  output io_dec_t     dec
);

  localparam logic [8:0] EXT_END = 9'(96 + EXT_NUM);
  localparam logic [7:0] FLAG_DA = 8'({2'b00, FLAG_IO}) + IO_WIN_BASE;

  logic [7:0] daddr;
  logic       legal;
  logic       rsvd;
  logic [5:0] io_idx;

  // translate the request address into one data address and judge its type
  always_comb begin
    legal = 1'b0;
    daddr = addr;
    unique case (op)
      OP_IO_RD, OP_IO_WR: begin
        legal = (addr[7:6] == 2'b00);
        daddr = addr + IO_WIN_BASE;
      end
      OP_BIT_SET, OP_BIT_CLR, OP_BIT_TST: begin
        legal = (addr[7:5] == 3'b000);
        daddr = addr + IO_WIN_BASE;
      end
      OP_MEM_RD, OP_MEM_WR: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  assign io_idx = 6'(daddr - IO_WIN_BASE);

  always_comb begin
    if (daddr < IO_WIN_BASE)       rsvd = 1'b1;
    else if (daddr < EXT_WIN_BASE) rsvd = IO_RSVD[io_idx];
    else                           rsvd = ({1'b0, daddr} >= EXT_END);
  end

  assign dec = '{legal: legal, reserved: rsvd, is_flag: (daddr == FLAG_DA), daddr: daddr};

endmodule

// File: rtl/iospace_regfile.sv
module iospace_regfile #(
  parameter int unsigned EXT_NUM  = 32,
  parameter logic [7:0]  FLAG_W1C = 8'h0F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       acc_en,
  input  logic       flag_sel,
  input  logic [7:0] daddr,
  input  logic       wr_en,
  input  logic [7:0] wmask,
  input  logic [7:0] wval,
  input  logic [7:0] hw_set,
  output logic [7:0] rd_val
);

  localparam int unsigned DEPTH  = 64 + EXT_NUM;
  localparam int unsigned SLOT_W = $clog2(DEPTH);

  logic [7:0]        regs [DEPTH];
  logic [7:0]        flag_q;
  logic [7:0]        flag_d;
  logic [7:0]        fmask;
  logic [7:0]        clr_ones;
  logic [SLOT_W-1:0] slot;
  logic              mem_sel;

  assign slot    = SLOT_W'(daddr - 8'h20);
  assign mem_sel = acc_en && !flag_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= 8'h00;
    end else if (mem_sel && wr_en) begin
      regs[slot] <= (regs[slot] & ~wmask) | (wval & wmask);
    end
  end

  // flag register: plain bits take masked data, flag bits clear on written ones
  assign fmask    = (acc_en && flag_sel && wr_en) ? wmask : 8'h00;
  assign clr_ones = fmask & wval;
  assign flag_d   = (((flag_q & ~fmask) | (wval & fmask)) & ~FLAG_W1C)
                  | (((flag_q & ~clr_ones) | hw_set) & FLAG_W1C);

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 8'h00;
    else     flag_q <= flag_d;
  end

  always_comb begin
    if (!acc_en)      rd_val = 8'h00;
    else if (flag_sel) rd_val = flag_q;
    else               rd_val = regs[slot];
  end

endmodule

// File: rtl/iospace_decoder.sv
module iospace_decoder
  import iospace_pkg::*;
#(
  parameter int unsigned EXT_NUM  = 32,
  parameter logic [63:0] IO_RSVD  = 64'h000F_0000_2000_0000,
  parameter logic [5:0]  FLAG_IO  = 6'h16,
  parameter logic [7:0]  FLAG_W1C = 8'h0F
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  input  logic [2:0] req_bit,
  input  logic [7:0] hw_flag_set,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       rsp_bit,
  output logic       rsp_illegal
);

  io_op_e     op;
  io_dec_t    dec;
  logic       acc_en;
  logic       wr_en;
  logic       byte_rd;
  logic [7:0] wmask;
  logic [7:0] wval;
  logic [7:0] rd_val;

  assign op = io_op_e'(req_op);

  iospace_map #(.EXT_NUM(EXT_NUM), .IO_RSVD(IO_RSVD), .FLAG_IO(FLAG_IO)) u_map (
    .op   (op),
    .addr (req_addr),
    .dec  (dec)
  );

  assign acc_en  = req_valid && dec.legal && !dec.reserved;
  assign byte_rd = (op == OP_IO_RD) || (op == OP_MEM_RD);

  // a bit operation becomes a one-bit masked write, a byte write a full mask
  always_comb begin
    wr_en = 1'b0;
    wmask = 8'h00;
    wval  = 8'h00;
    unique case (op)
      OP_IO_WR, OP_MEM_WR: begin wr_en = 1'b1; wmask = 8'hFF; wval = req_wdata; end
      OP_BIT_SET:          begin wr_en = 1'b1; wmask = 8'h01 << req_bit; wval = 8'hFF; end
      OP_BIT_CLR:          begin wr_en = 1'b1; wmask = 8'h01 << req_bit; wval = 8'h00; end
      default:             wr_en = 1'b0;
    endcase
  end

  iospace_regfile #(.EXT_NUM(EXT_NUM), .FLAG_W1C(FLAG_W1C)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .acc_en   (acc_en),
    .flag_sel (dec.is_flag),
    .daddr    (dec.daddr),
    .wr_en    (wr_en),
    .wmask    (wmask),
    .wval     (wval),
    .hw_set   (hw_flag_set),
    .rd_val   (rd_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= 8'h00;
      rsp_bit     <= 1'b0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_illegal <= req_valid && !dec.legal;
      rsp_rdata   <= (acc_en && byte_rd) ? rd_val : 8'h00;
      rsp_bit     <= acc_en && (op == OP_BIT_TST) && rd_val[req_bit];
    end
  end

endmodule

// File: rtl/iospace_decoder_chk.sv
module iospace_decoder_chk #(
  parameter logic [63:0] IO_RSVD = 64'h000F_0000_2000_0000
) (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_op,
  input logic [7:0] req_addr,
  input logic       rsp_valid,
  input logic [7:0] rsp_rdata,
  input logic       rsp_bit,
  input logic       rsp_illegal
);

  logic is_write, is_bitop, is_io;
  assign is_write = (req_op == 3'd1) || (req_op == 3'd3) || (req_op == 3'd4) || (req_op == 3'd5);
  assign is_bitop = (req_op == 3'd4) || (req_op == 3'd5) || (req_op == 3'd6);
  assign is_io    = (req_op == 3'd0) || (req_op == 3'd1);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    rst |=> !rsp_valid && !rsp_illegal);

  a_r3_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r3_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r3_write_no_data: assert property (@(posedge clk) disable iff (rst)
    req_valid && is_write |=> rsp_rdata == 8'h00);

  a_r5_bit_only_on_test: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_op == 3'd6) |=> !rsp_bit);

  a_r6_high_bitop_illegal: assert property (@(posedge clk) disable iff (rst)
    req_valid && is_bitop && req_addr >= 8'h20 |=> rsp_illegal);

  a_r6_illegal_with_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> rsp_valid);

  a_r7_high_io_illegal: assert property (@(posedge clk) disable iff (rst)
    req_valid && is_io && req_addr >= 8'h40 |=> rsp_illegal && rsp_rdata == 8'h00);

  a_r11_reserved_io_zero: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'd0 && req_addr < 8'h40 && IO_RSVD[req_addr[5:0]]
      |=> rsp_rdata == 8'h00 && !rsp_illegal);

  a_r12_undefined_op: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_op == 3'd7 |=> rsp_illegal);

endmodule

bind iospace_decoder iospace_decoder_chk #(.IO_RSVD(IO_RSVD)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_op      (req_op),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_bit     (rsp_bit),
  .rsp_illegal (rsp_illegal)
);

// File: tb/test_iospace_decoder.sv
module test_iospace_decoder;
  import iospace_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic [2:0] req_bit = 3'd0;
  logic [7:0] hw_flag_set = 8'h00;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       rsp_bit;
  logic       rsp_illegal;

  always #5 clk = ~clk;

  iospace_decoder i_iospace_decoder (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bit(req_bit),
    .hw_flag_set(hw_flag_set), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_bit(rsp_bit), .rsp_illegal(rsp_illegal)
  );

  logic [9:0] exp_q[$];
  string      tag_q[$];
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  // driver: present one request and queue what must come back
  task automatic issue(input io_op_e op, input logic [7:0] a, input logic [7:0] w,
                       input logic [2:0] b, input logic [7:0] hw,
                       input logic [7:0] erd, input logic ebit, input logic eill,
                       input string tag);
    @(negedge clk);
    req_valid   = 1'b1;
    req_op      = op;
    req_addr    = a;
    req_wdata   = w;
    req_bit     = b;
    hw_flag_set = hw;
    exp_q.push_back({erd, ebit, eill});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid   = 1'b0;
      hw_flag_set = 8'h00;
    end
  endtask

  // monitor: compare each response against the head of the queue
  always @(negedge clk) begin
    if (!rst && !done && rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected response: rdata=%h bit=%b ill=%b expected none",
                 rsp_rdata, rsp_bit, rsp_illegal);
      end else begin
        logic [9:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_rdata, rsp_bit, rsp_illegal} !== e) begin
          failures++;
          $display("FAIL %s: rdata=%h bit=%b ill=%b expected rdata=%h bit=%b ill=%b",
                   t, rsp_rdata, rsp_bit, rsp_illegal, e[9:2], e[1], e[0]);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_illegal !== 1'b0) begin
      failures++;
      $display("FAIL R1 in reset: valid=%b ill=%b expected 0 0", rsp_valid, rsp_illegal);
    end
    rst = 1'b0;

    // R1: registers cleared
    issue(OP_IO_RD,  8'h00, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R1 io 0x00 after reset");
    issue(OP_MEM_RD, 8'h70, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R1 ext 0x70 after reset");
    // R2: general registers and dual view
    issue(OP_IO_WR,  8'h00, 8'hFF, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R3 write returns zero");
    issue(OP_IO_WR,  8'h01, 8'h81, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R3 write returns zero");
    issue(OP_IO_WR,  8'h02, 8'h7E, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R3 write returns zero");
    issue(OP_IO_RD,  8'h00, 8'h00, 3'd0, 8'h00, 8'hFF, 1'b0, 1'b0, "R2 gpr 0x00");
    issue(OP_IO_RD,  8'h01, 8'h00, 3'd0, 8'h00, 8'h81, 1'b0, 1'b0, "R2 gpr 0x01");
    issue(OP_MEM_RD, 8'h22, 8'h00, 3'd0, 8'h00, 8'h7E, 1'b0, 1'b0, "R2 gpr 0x02 via data 0x22");
    issue(OP_IO_WR,  8'h05, 8'hA5, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R2 write io 0x05");
    issue(OP_MEM_RD, 8'h25, 8'h00, 3'd0, 8'h00, 8'hA5, 1'b0, 1'b0, "R2 data 0x25 aliases io 0x05");
    issue(OP_MEM_WR, 8'h5A, 8'h3C, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R2 write data 0x5A");
    issue(OP_IO_RD,  8'h3A, 8'h00, 3'd0, 8'h00, 8'h3C, 1'b0, 1'b0, "R2 io 0x3A aliases data 0x5A");
    idle(2);
    // R4 / R5: bit operations
    issue(OP_BIT_SET, 8'h05, 8'h00, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, "R4 set bit1");
    issue(OP_BIT_CLR, 8'h05, 8'h00, 3'd7, 8'h00, 8'h00, 1'b0, 1'b0, "R4 clear bit7");
    issue(OP_IO_RD,   8'h05, 8'h00, 3'd0, 8'h00, 8'h27, 1'b0, 1'b0, "R4 only named bits changed");
    issue(OP_BIT_TST, 8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0, "R5 test bit0 one");
    issue(OP_BIT_TST, 8'h05, 8'h00, 3'd3, 8'h00, 8'h00, 1'b0, 1'b0, "R5 test bit3 zero");
    issue(OP_BIT_TST, 8'h00, 8'h00, 3'd7, 8'h00, 8'h00, 1'b1, 1'b0, "R5 test gpr bit7");
    // R6: bit ops above the low range
    issue(OP_BIT_SET, 8'h3A, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1, "R6 set at 0x3A illegal");
    issue(OP_IO_RD,   8'h3A, 8'h00, 3'd0, 8'h00, 8'h3C, 1'b0, 1'b0, "R6 0x3A unchanged");
    issue(OP_BIT_TST, 8'h25, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1, "R6 test at 0x25 illegal");
    // R7 / R8: extended range
    issue(OP_MEM_WR, 8'h65, 8'h77, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R8 write ext 0x65");
    issue(OP_IO_WR,  8'h65, 8'h11, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1, "R7 io write 0x65 illegal");
    issue(OP_MEM_RD, 8'h65, 8'h00, 3'd0, 8'h00, 8'h77, 1'b0, 1'b0, "R8 ext 0x65 kept");
    issue(OP_IO_RD,  8'h65, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1, "R7 io read 0x65 illegal");
    issue(OP_MEM_WR, 8'h7F, 8'h9C, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R8 write ext 0x7F");
    issue(OP_MEM_RD, 8'h7F, 8'h00, 3'd0, 8'h00, 8'h9C, 1'b0, 1'b0, "R8 ext 0x7F");
    // R9 / R10: flag register
    issue(OP_IO_RD,   8'h16, 8'h00, 3'd0, 8'hFF, 8'h00, 1'b0, 1'b0, "R9 read before set");
    issue(OP_IO_RD,   8'h16, 8'h00, 3'd0, 8'h00, 8'h0F, 1'b0, 1'b0, "R9 only flag bits set");
    issue(OP_IO_WR,   8'h16, 8'h55, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R9 write ones clear");
    issue(OP_IO_RD,   8'h16, 8'h00, 3'd0, 8'h00, 8'h5A, 1'b0, 1'b0, "R9 after write");
    issue(OP_BIT_SET, 8'h16, 8'h00, 3'd1, 8'h00, 8'h00, 1'b0, 1'b0, "R10 set on flag1");
    issue(OP_IO_RD,   8'h16, 8'h00, 3'd0, 8'h00, 8'h58, 1'b0, 1'b0, "R10 only flag1 cleared");
    issue(OP_BIT_CLR, 8'h16, 8'h00, 3'd3, 8'h00, 8'h00, 1'b0, 1'b0, "R10 clear on flag3");
    issue(OP_IO_RD,   8'h16, 8'h00, 3'd0, 8'h00, 8'h58, 1'b0, 1'b0, "R10 flag3 kept");
    issue(OP_BIT_CLR, 8'h16, 8'h00, 3'd6, 8'h00, 8'h00, 1'b0, 1'b0, "R10 clear plain bit6");
    issue(OP_BIT_SET, 8'h16, 8'h00, 3'd7, 8'h00, 8'h00, 1'b0, 1'b0, "R10 set plain bit7");
    issue(OP_MEM_RD,  8'h36, 8'h00, 3'd0, 8'h00, 8'h98, 1'b0, 1'b0, "R10 flags via data 0x36");
    // R13: set beats clear
    issue(OP_IO_WR,  8'h16, 8'h01, 3'd0, 8'h01, 8'h00, 1'b0, 1'b0, "R13 write with event");
    issue(OP_IO_RD,  8'h16, 8'h00, 3'd0, 8'h00, 8'h09, 1'b0, 1'b0, "R13 flag0 stays set");
    // R11: reserved locations
    issue(OP_IO_WR,   8'h1D, 8'hFF, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 write rsvd 0x1D");
    issue(OP_IO_RD,   8'h1D, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 rsvd 0x1D reads zero");
    issue(OP_BIT_SET, 8'h1D, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 bit set rsvd legal");
    issue(OP_BIT_TST, 8'h1D, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 bit test rsvd zero");
    issue(OP_IO_RD,   8'h1C, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 neighbour 0x1C");
    issue(OP_IO_RD,   8'h1E, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 neighbour 0x1E");
    issue(OP_MEM_WR,  8'h80, 8'h12, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 write data 0x80");
    issue(OP_MEM_RD,  8'h80, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 data 0x80 zero");
    issue(OP_MEM_RD,  8'h7F, 8'h00, 3'd0, 8'h00, 8'h9C, 1'b0, 1'b0, "R11 ext 0x7F intact");
    issue(OP_MEM_WR,  8'h10, 8'hAB, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 write data 0x10");
    issue(OP_MEM_RD,  8'h10, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 data 0x10 zero");
    issue(OP_MEM_WR,  8'h50, 8'h44, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 write rsvd io 0x30");
    issue(OP_IO_RD,   8'h30, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 io 0x30 zero");
    issue(OP_IO_RD,   8'h2F, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 neighbour 0x2F");
    issue(OP_IO_RD,   8'h34, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, "R11 neighbour 0x34");
    // R12: undefined op
    issue(OP_NONE,   8'h05, 8'h00, 3'd0, 8'h00, 8'h00, 1'b0, 1'b1, "R12 op 7 illegal");
    issue(OP_IO_RD,  8'h05, 8'h00, 3'd0, 8'h00, 8'h27, 1'b0, 1'b0, "R12 io 0x05 unchanged");
    idle(4);

    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R3 missing responses: outstanding=%0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule